// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block is a clocked sequencer that runs an external asynchronous static RAM of 32K bytes. A requester hands it one access at a time on a valid/ready handshake: a write carries an address and a byte, and a read carries an address and gets its byte back on a one-cycle response pulse. The controller produces the active-low chip-select, write-strobe and output-enable lines for the memory. It also drives the 15-bit address and the outgoing byte, and controls the enable of the pad's tri-state data driver.

Each timing minimum of the memory is given in nanoseconds as a parameter. Next to it sits the clock period the block is built for. Every minimum becomes a whole number of cycles, rounded up and never below one. A write is the overlap of chip-select low and write-strobe low. The controller ends it by raising both strobes on the same edge and keeps address and data on the pins for one more cycle. Output-enable stays high for the whole write, so the memory never drives the bus while the controller does.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and right after reset, memCeN, memWeN and memOeN are 1, memDqOe is 0, reqReady is 1 and rspValid is 0.
- R2: reqReady is 1 only while the controller is idle. A request is taken on a clock edge where reqValid and reqReady are both 1. reqWrite=1 selects a write and reqWrite=0 selects a read.
- R3: A write has one setup cycle (memCeN=0, memWeN=1) followed by exactly STRB cycles with memWeN=0, where STRB is the largest of the pulse, data-setup and address-setup counts. memWeN is 0 only while memCeN is 0 and memOeN is 1, and memWeN and memCeN rise on the same edge.
- R4: During a write, memAddr and memDqOut stay constant from the setup cycle through the cycle after the strobes rise. Data is driven for at least the data-setup count of cycles before the write ends.
- R5: memDqOe is 1 only in a cycle where memOeN is 1 and was also 1 in the cycle before. It is 0 in idle, in recovery and during reads.
- R6: After a write is taken, reqReady stays 0 for max(WC, STRB+2) cycles, so that one write cycle lasts at least the write-cycle minimum.
- R7: A read holds memCeN=0, memOeN=0 and memWeN=1 for ACC cycles and samples memDqIn on the last edge of that window. Then memOeN and memCeN go to 1, rspValid is 1 for exactly one cycle with the sampled byte on rspRdata, and reqReady stays 0 for ACC+1 cycles in total.
- R8: Each cycle count is ceil(ns / CLK_NS) of its parameter, and at least 1.
- R9: A read returns the byte most recently written to the same address, including address 0 and address 2^ADDR_W-1, and including a read issued right after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write byte |
| reqReady | output | 1 | Controller idle, request can be taken |
| rspValid | output | 1 | Read data valid, one-cycle pulse |
| rspRdata | output | DATA_W | Read data |
| memCeN | output | 1 | Memory chip-select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | ADDR_W | Memory address bus |
| memDqOut | output | DATA_W | Outgoing data to the pad driver |
| memDqOe | output | 1 | Pad tri-state driver enable |
| memDqIn | input | DATA_W | Incoming data from the pads |

## Verification
The embedded properties assume that reset is held for at least one edge. They also assume the requester changes its request fields only between edges, so a taken request is the one seen on the accepting edge. The bench drives every input on the falling clock edge and releases reqValid right after acceptance. It uses a behavioural memory model that returns stored bytes only while chip-select and output-enable are low with the write strobe high. That model counts overlap lengths, data stability and driver/output-enable conflicts in cycles. It runs with a short assumed clock period and a long write-cycle minimum, so the multi-cycle strobe, recovery padding and access window all take more than one cycle.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  // Strobe bundle from control to datapath, decoded for the coming cycle
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;
    logic rsp;
    logic load;
    logic capture;
  } strobe_t;

  // Cycles needed to cover ns at a period of per, never below one
  function automatic int cycCount(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_strobe_pkg::*;
#(
  parameter int STRB_CYC = 1,
  parameter int REC_CYC  = 0,
  parameter int ACC_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t ctlNext
);

  localparam int MAX_CYC = maxOf(maxOf(STRB_CYC, ACC_CYC), maxOf(REC_CYC, 1));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STROBE, S_ENDW, S_RECOV, S_RDACC, S_RDDONE
  } state_e;

  state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic loadD, captureD;

  always_comb begin
    stateD   = stateQ;
    cntD     = cntQ;
    loadD    = 1'b0;
    captureD = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          loadD = 1'b1;
          if (reqWrite) begin
            stateD = S_SETUP;
          end else begin
            stateD = S_RDACC;
            cntD   = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      S_SETUP: begin
        stateD = S_STROBE;
        cntD   = CNT_W'(STRB_CYC - 1);
      end
      S_STROBE: begin
        if (cntQ == '0) stateD = S_ENDW;
        else            cntD   = cntQ - 1'b1;
      end
      S_ENDW: begin
        if (REC_CYC > 0) begin
          stateD = S_RECOV;
          cntD   = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
        end else begin
          stateD = S_IDLE;
        end
      end
      S_RECOV: begin
        if (cntQ == '0) stateD = S_IDLE;
        else            cntD   = cntQ - 1'b1;
      end
      S_RDACC: begin
        if (cntQ == '0) begin
          captureD = 1'b1;
          stateD   = S_RDDONE;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      S_RDDONE: stateD = S_IDLE;
      default:  stateD = S_IDLE;
    endcase
  end

  // Strobes for the next cycle, registered in the datapath
  always_comb begin
    ctlNext.ceN     = !(stateD inside {S_SETUP, S_STROBE, S_RDACC});
    ctlNext.weN     = (stateD != S_STROBE);
    ctlNext.oeN     = (stateD != S_RDACC);
    ctlNext.drive   = (stateD inside {S_SETUP, S_STROBE, S_ENDW});
    ctlNext.rsp     = (stateD == S_RDDONE);
    ctlNext.load    = loadD;
    ctlNext.capture = captureD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign reqReady = (stateQ == S_IDLE);

  // R2: the controller leaves idle only through a handshake
  p_ready_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid));

  // R3: the strobe phase is always entered from the setup cycle
  p_strobe_after_setup_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_STROBE && $past(stateQ) != S_STROBE) |-> $past(stateQ) == S_SETUP);

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctlNext,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memDqOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memDqOe  <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      memCeN   <= ctlNext.ceN;
      memWeN   <= ctlNext.weN;
      memOeN   <= ctlNext.oeN;
      memDqOe  <= ctlNext.drive;
      rspValid <= ctlNext.rsp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      rspRdata <= '0;
    end else begin
      if (ctlNext.load) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      if (ctlNext.capture) rspRdata <= memDqIn;
    end
  end

  // R3: write strobe only inside chip-select, with output-enable high
  p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN));

  // R3: the write ends with both strobes rising together
  p_we_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> $rose(memCeN));

  // R4: address held steady while chip-select stays low
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R5: driver only after output-enable has been high a full cycle
  p_drv_after_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && $past(memOeN)));

  // R7: response is a single-cycle pulse
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int PWE_NS = 8,
  parameter int SD_NS  = 7,
  parameter int AW_NS  = 9,
  parameter int WC_NS  = 10,
  parameter int ACC_NS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  // R8: nanosecond minimums rounded up to whole cycles
  localparam int PWE_CYC  = cycCount(PWE_NS, CLK_NS);
  localparam int SD_CYC   = cycCount(SD_NS,  CLK_NS);
  localparam int AW_CYC   = cycCount(AW_NS,  CLK_NS);
  localparam int WC_CYC   = cycCount(WC_NS,  CLK_NS);
  localparam int ACC_CYC  = cycCount(ACC_NS, CLK_NS);
  localparam int STRB_CYC = maxOf(PWE_CYC, maxOf(SD_CYC, AW_CYC));
  localparam int REC_CYC  = maxOf(WC_CYC - STRB_CYC - 2, 0);

  strobe_t ctlNext;

  sram_strobe_fsm #(
    .STRB_CYC(STRB_CYC),
    .REC_CYC (REC_CYC),
    .ACC_CYC (ACC_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ctlNext (ctlNext)
  );

  sram_strobe_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctlNext (ctlNext),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memDqOe (memDqOe),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int T_CLK = 4, T_PWE = 8, T_SD = 7, T_AW = 9, T_WC = 30, T_ACC = 10;

  function automatic int cdiv(input int a, input int b);
    int c;
    c = (a + b - 1) / b;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PWE   = cdiv(T_PWE, T_CLK);
  localparam int E_SD    = cdiv(T_SD, T_CLK);
  localparam int E_AW    = cdiv(T_AW, T_CLK);
  localparam int E_WC    = cdiv(T_WC, T_CLK);
  localparam int E_ACC   = cdiv(T_ACC, T_CLK);
  localparam int E_STRB  = imax(E_PWE, imax(E_SD, E_AW));
  localparam int E_BUSYW = imax(E_WC, E_STRB + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, memCeN, memWeN, memOeN, memDqOe;
  logic [DW-1:0] rspRdata, memDqOut, memDqIn;
  logic [AW-1:0] memAddr;

  always #5 clk = ~clk;

  sram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(T_CLK), .PWE_NS(T_PWE),
    .SD_NS(T_SD), .AW_NS(T_AW), .WC_NS(T_WC), .ACC_NS(T_ACC)
  ) i_sram_strobe_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int testCnt = 0, failCnt = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural memory, evaluated on the falling edge
  logic [DW-1:0] model [int];
  int violPulse = 0, violHold = 0, violDrive = 0, lastPulse = 0;
  int ovCnt = 0, dStab = 0;
  logic prevOv = 1'b0, prevOeN = 1'b1, prevDqOe = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevDq = '0;

  always_comb begin
    if (!memCeN && !memOeN && memWeN && model.exists(int'(memAddr)))
      memDqIn = model[int'(memAddr)];
    else
      memDqIn = '0;
  end

  always @(negedge clk) begin
    logic curOv;
    int prevStab;
    if (rstN) begin
      curOv = !memCeN && !memWeN;
      prevStab = dStab;
      if (!memWeN && memCeN) violPulse++;
      if (memDqOe && (!memOeN || !prevOeN)) violDrive++;
      if (curOv && prevOv && memAddr != prevAddr) violHold++;
      if (curOv) ovCnt++;
      if (prevOv && !curOv) begin
        lastPulse = ovCnt;
        if (ovCnt < E_PWE) violPulse++;
        if (prevStab < E_SD) violPulse++;
        if (!memDqOe || memDqOut != prevDq || memAddr != prevAddr) violHold++;
        model[int'(prevAddr)] = prevDq;
        ovCnt = 0;
      end
      dStab = (memDqOe && prevDqOe && memDqOut == prevDq) ? dStab + 1 : (memDqOe ? 1 : 0);
      prevOv = curOv; prevOeN = memOeN; prevDqOe = memDqOe;
      prevAddr = memAddr; prevDq = memDqOut;
    end
  end

  function automatic logic [DW-1:0] dataOf(input int a);
    return DW'(a * 37 + (a >> 7) + 5);
  endfunction

  task automatic doWrite(input int a, input logic [DW-1:0] d, input bit chkPulse);
    int busy;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(a); reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqAddr = '1; reqWdata = ~d;
    busy = 0;
    while (!reqReady) begin
      busy++;
      @(negedge clk);
    end
    check("R6 write busy cycles", busy, E_BUSYW);
    if (chkPulse) check("R3 R8 strobe length", lastPulse, E_STRB);
  endtask

  task automatic doRead(input int a, input logic [DW-1:0] exp);
    int n;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqAddr = '0;
    n = 1;
    while (!rspValid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R7 read latency", n, E_ACC + 1);
    check("R9 read data", int'(rspRdata), int'(exp));
    @(negedge clk);
    check("R7 single pulse", int'(rspValid), 0);
    check("R2 ready after read", int'(reqReady), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 ceN", int'(memCeN), 1);
    check("R1 weN", int'(memWeN), 1);
    check("R1 oeN", int'(memOeN), 1);
    check("R1 dqOe", int'(memDqOe), 0);
    check("R1 ready", int'(reqReady), 1);
    check("R1 rspValid", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after release", int'(reqReady), 1);

    // Sweep: strided writes, then read all back
    for (int i = 0; i < 1024; i++) doWrite((i * 67) % 32768, dataOf((i * 67) % 32768), (i < 16));
    for (int i = 0; i < 1024; i++) doRead((i * 67) % 32768, dataOf((i * 67) % 32768));

    // Boundary addresses, write immediately followed by read
    doWrite(0, 8'hA5, 1'b1);
    doRead(0, 8'hA5);
    doWrite(32767, 8'h3C, 1'b1);
    doRead(32767, 8'h3C);
    doWrite(0, 8'h00, 1'b0);
    doWrite(32767, 8'hFF, 1'b0);
    doRead(0, 8'h00);
    doRead(32767, 8'hFF);

    // Idle: no strobes, no driver
    repeat (2) @(negedge clk);
    check("R5 driver off in idle", int'(memDqOe), 0);
    check("R3 strobe inactive in idle", int'(memWeN), 1);

    check("R3 overlap violations", violPulse, 0);
    check("R4 hold violations", violHold, 0);
    check("R5 drive violations", violDrive, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule